// File: doc/BRIEF.md
# Card Status Change Event Queue

This block watches the card-detect pin pair of each of two card sockets and turns detect changes into insert and remove events for a host. Each socket also delivers a one-cycle status-change pulse. The block looks at that socket's detect pins only in a cycle where the pulse is high, which stands for one read-and-clear of the socket's change status. It decodes the pin pair and throws away events that would not change the socket's attached state. Accepted events go into one small queue that both sockets share.

The host drains the queue through a valid/ready pop port. Each entry carries a channel bit and a two-bit event code. When the queue has no room, an event is lost and a one-cycle overflow pulse is raised. The detect inputs are expected to be synchronised already. No debouncing is done beyond the decode described below.

Back-pressure rules on the pop port:
- `evt_valid_o` is high whenever the queue holds at least one entry.
- While `evt_valid_o` is high and `evt_ready_i` is low, the channel and code outputs hold their values.
- An entry leaves the queue on a rising clock edge where both `evt_valid_o` and `evt_ready_i` are high.
- The host may hold `evt_ready_i` low for as long as it likes. Events that arrive while the queue is full are dropped and reported on `ovf_o`.

Top module: `csc_event_queue`

## Requirements
- R1: With the change pulse high, both detect pins high decode to REMOVE, which is code 2. Both pins low decode to INSERT, which is code 1. Mixed pins are an in-transition state that enqueues nothing. The channel bit of an entry is 0 for socket 0 and 1 for socket 1. Code 0 is never popped.
- R2: In a cycle where a channel's change pulse is low, that channel's detect pins are not evaluated and nothing is enqueued for it.
- R3: An INSERT on a channel already marked attached is dropped as spurious. So is a REMOVE on a channel not marked attached. A spurious drop enqueues nothing and raises no overflow when room exists.
- R4: When an event is accepted, the channel's attached flag becomes 1 for INSERT and 0 for REMOVE. An event lost to overflow leaves the flag unchanged.
- R5: The queue holds at most DEPTH entries (5 by default), shared by both channels. An event that finds no free slot is discarded. `ovf_o` is then high for exactly the one cycle after the edge that dropped it.
- R6: Entries pop in acceptance order. When both channels are accepted in the same cycle, channel 0 comes out before channel 1.
- R7: `evt_valid_o` is high exactly when the queue is not empty. While it is high and `evt_ready_i` is low, the popped fields stay stable.
- R8: After reset the queue is empty, both attached flags are 0, and `evt_valid_o` and `ovf_o` are low.
- R9: Room is judged on the occupancy before this cycle's pop. A slot freed by a pop can take a new event only from the next cycle on.
- R10: The room check comes before the spurious check. An event that would be spurious, arriving while the queue is full, still raises `ovf_o`.
- R11: When both channels report in one cycle and only one slot is free, channel 0 takes the slot and channel 1 is dropped with an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_a_i | input | 2 | First detect pin per channel (bit c = channel c) |
| cd_b_i | input | 2 | Second detect pin per channel |
| chg_i | input | 2 | Status-change pulse per channel |
| evt_valid_o | output | 1 | Queue head is valid |
| evt_ready_i | input | 1 | Host accepts the head entry |
| evt_chan_o | output | 1 | Channel of the head entry |
| evt_code_o | output | 2 | Event code of the head entry (1 insert, 2 remove) |
| ovf_o | output | 1 | One-cycle pulse: an event was dropped for lack of room |

## Verification
A wrong attached flag shows up on the next change pulse of that channel. An event that should be accepted goes missing from the pop port, or a spurious one appears, one cycle after the pulse. A queue pointer or occupancy error shows up as a wrong head entry or a wrong valid level at the next pop. It can also surface as an overflow pulse at the wrong fill level, one cycle after the offending pulse. The bench therefore compares the pop port and the overflow pin against an arithmetic model on every cycle, so any divergence is caught within one clock.

// File: rtl/csc_pkg.sv
package csc_pkg;
  // Socket count is fixed at two; the entry format carries one channel bit.
  localparam int NUM_CH = 2;
  localparam int CH_W   = 1;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_INSERT = 2'd1,
    EV_REMOVE = 2'd2
  } ev_code_e;

  typedef struct packed {
    logic [CH_W-1:0] chan;
    ev_code_e        code;
  } ev_entry_t;
endpackage

// File: rtl/csc_detect_decode.sv
// Turns one socket's detect pin pair into an event code, gated by its change pulse.
module csc_detect_decode
  import csc_pkg::*;
(
  input  logic     chg_i,
  input  logic     cd_a_i,
  input  logic     cd_b_i,
  output ev_code_e code_o
);
  always_comb begin
    code_o = EV_NONE;
    if (chg_i) begin
      if (cd_a_i && cd_b_i)        code_o = EV_REMOVE;
      else if (!cd_a_i && !cd_b_i) code_o = EV_INSERT;
    end
  end
endmodule

// File: rtl/csc_admit.sv
// Admission: room check first, then the spurious filter; keeps per-channel attached flags.
module csc_admit
  import csc_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ev_code_e          code_i [NUM_CH],
  input  logic [CNT_W-1:0]  occ_i,
  output logic [NUM_CH-1:0] push_o,
  output logic              ovf_o
);
  localparam int SUM_W = $clog2(DEPTH + NUM_CH + 1);

  logic [SUM_W-1:0]  fill [NUM_CH+1];
  logic [NUM_CH-1:0] full_hit;

  assign fill[0] = SUM_W'(occ_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic has_ev, room, spur, att_q;

    assign has_ev = (code_i[c] != EV_NONE);
    assign room   = (fill[c] < SUM_W'(DEPTH));
    assign spur   = ((code_i[c] == EV_INSERT) && att_q) ||
                    ((code_i[c] == EV_REMOVE) && !att_q);

    assign push_o[c]   = has_ev && room && !spur;
    assign full_hit[c] = has_ev && !room;
    assign fill[c+1]   = fill[c] + SUM_W'(push_o[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         att_q <= 1'b0;
      else if (push_o[c]) att_q <= (code_i[c] == EV_INSERT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_o <= 1'b0;
    else        ovf_o <= |full_hit;
  end
endmodule

// File: rtl/csc_fifo.sv
// Circular store of DEPTH entries; up to NUM_CH pushes per cycle in channel order, one pop.
module csc_fifo
  import csc_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] push_i,
  input  ev_entry_t         data_i [NUM_CH],
  input  logic              pop_i,
  output ev_entry_t         head_o,
  output logic [CNT_W-1:0]  occ_o
);
  ev_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [PTR_W-1:0] slot [NUM_CH];
  logic [CNT_W-1:0] n_push;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p, input int n);
    int s;
    s = (int'(p) + n) % DEPTH;
    return PTR_W'(s);
  endfunction

  always_comb begin
    int k;
    k = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      slot[c] = adv(wr_ptr, k);
      if (push_i[c]) k++;
    end
    n_push = CNT_W'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ_o  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (push_i[c]) mem[slot[c]] <= data_i[c];
      if (pop_i) rd_ptr <= adv(rd_ptr, 1);
      wr_ptr <= adv(wr_ptr, int'(n_push));
      occ_o  <= occ_o + n_push - CNT_W'(pop_i);
    end
  end

  assign head_o = mem[rd_ptr];
endmodule

// File: rtl/csc_event_queue.sv
// Top: per-channel decode, shared admission, shared event queue with a valid/ready pop port.
module csc_event_queue
  import csc_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cd_a_i,
  input  logic [NUM_CH-1:0] cd_b_i,
  input  logic [NUM_CH-1:0] chg_i,
  output logic              evt_valid_o,
  input  logic              evt_ready_i,
  output logic [CH_W-1:0]   evt_chan_o,
  output logic [1:0]        evt_code_o,
  output logic              ovf_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  ev_code_e          code [NUM_CH];
  ev_entry_t         ent  [NUM_CH];
  logic [NUM_CH-1:0] push;
  logic [CNT_W-1:0]  occ;
  ev_entry_t         head;
  logic              pop;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    csc_detect_decode u_dec (
      .chg_i  (chg_i[c]),
      .cd_a_i (cd_a_i[c]),
      .cd_b_i (cd_b_i[c]),
      .code_o (code[c])
    );
    assign ent[c].chan = CH_W'(c);
    assign ent[c].code = code[c];
  end

  csc_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_admit (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_i (code),
    .occ_i  (occ),
    .push_o (push),
    .ovf_o  (ovf_o)
  );

  csc_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push),
    .data_i (ent),
    .pop_i  (pop),
    .head_o (head),
    .occ_o  (occ)
  );

  assign evt_valid_o = (occ != '0);
  assign pop         = evt_valid_o && evt_ready_i;
  assign evt_chan_o  = head.chan;
  assign evt_code_o  = head.code;
endmodule

// File: rtl/csc_event_queue_chk.sv
module csc_event_queue_chk #(
  parameter int DEPTH  = 5,
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chg_i,
  input logic              evt_valid_o,
  input logic              evt_ready_i,
  input logic              evt_chan_o,
  input logic [1:0]        evt_code_o,
  input logic              ovf_o,
  input logic [CNT_W-1:0]  occ
);
  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o && !evt_ready_i |=> evt_valid_o && $stable(evt_chan_o) && $stable(evt_code_o));

  // R1
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> (evt_code_o == 2'd1 || evt_code_o == 2'd2));

  // R2
  idle_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_i == '0) |=> (occ <= $past(occ)));

  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  // R5
  ovf_near_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (int'($past(occ)) + NUM_CH > DEPTH));

  // R8
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> !evt_valid_o && !ovf_o);
endmodule

bind csc_event_queue csc_event_queue_chk #(
  .DEPTH(DEPTH), .NUM_CH(csc_pkg::NUM_CH), .CNT_W($clog2(DEPTH + 1))
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chg_i       (chg_i),
  .evt_valid_o (evt_valid_o),
  .evt_ready_i (evt_ready_i),
  .evt_chan_o  (evt_chan_o),
  .evt_code_o  (evt_code_o),
  .ovf_o       (ovf_o),
  .occ         (occ)
);

// File: tb/test_csc_event_queue.sv
`timescale 1ns/1ps
module test_csc_event_queue;
  localparam int DEPTH = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cd_a = 2'b11, cd_b = 2'b11, chg = 2'b00;
  logic       rdy = 1'b0;
  logic       evt_valid, evt_chan, ovf;
  logic [1:0] evt_code;

  int nvec = 0;
  int nfail = 0;

  // model state
  bit       matt [2];
  bit [2:0] mq [$];

  always #2.5 clk = ~clk;

  csc_event_queue #(.DEPTH(DEPTH)) i_csc_event_queue (
    .clk(clk), .rst_n(rst_n), .cd_a_i(cd_a), .cd_b_i(cd_b), .chg_i(chg),
    .evt_valid_o(evt_valid), .evt_ready_i(rdy), .evt_chan_o(evt_chan),
    .evt_code_o(evt_code), .ovf_o(ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle, advance the model, compare after the edge.
  task automatic step(input logic [1:0] a, input logic [1:0] b,
                      input logic [1:0] c_chg, input logic r);
    int base, used;
    bit exp_ovf, popped;
    bit [1:0] code;
    @(negedge clk);
    cd_a = a; cd_b = b; chg = c_chg; rdy = r;
    base = mq.size(); used = 0; exp_ovf = 0;
    popped = (base > 0) && r;
    for (int c = 0; c < 2; c++) begin
      if (c_chg[c]) begin
        code = (a[c] && b[c]) ? 2'd2 : (!a[c] && !b[c]) ? 2'd1 : 2'd0;
        if (code != 2'd0) begin
          if (base + used >= DEPTH) exp_ovf = 1;                  // R5 R9 R10 R11
          else if ((code == 2'd1 && matt[c]) || (code == 2'd2 && !matt[c])) ; // R3
          else begin
            mq.push_back({c[0], code});
            used++;
            matt[c] = (code == 2'd1);                             // R4
          end
        end
      end
    end
    if (popped) void'(mq.pop_front());
    @(posedge clk);
    #1;
    check(evt_valid == (mq.size() > 0), "R7 valid level", evt_valid, mq.size() > 0);
    if (mq.size() > 0 && evt_valid)
      check({evt_chan, evt_code} == mq[0], "R6 head entry", {evt_chan, evt_code}, mq[0]);
    check(ovf == exp_ovf, "R5 overflow pulse", ovf, exp_ovf);
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!evt_valid && !ovf, "R8 reset state", {evt_valid, ovf}, 0);
    @(negedge clk) rst_n = 1'b1;

    // R4 R3: remove with no card attached after reset is spurious
    step(2'b01, 2'b01, 2'b01, 0);
    check(!evt_valid, "R3 spurious remove", evt_valid, 0);
    // R1: insert on channel 0
    step(2'b00, 2'b00, 2'b01, 0);
    check(evt_valid && evt_chan == 0 && evt_code == 2'd1, "R1 insert code",
          {evt_chan, evt_code}, 1);
    // R3: second insert is spurious
    step(2'b00, 2'b00, 2'b01, 0);
    // R1: mixed pins on channel 1
    step(2'b10, 2'b00, 2'b10, 0);
    // R2: pins low on channel 1 without pulse
    step(2'b00, 2'b00, 2'b00, 0);
    // R6: both channels in one cycle, with a pop
    step(2'b01, 2'b01, 2'b11, 1);
    check(evt_chan == 0 && evt_code == 2'd2, "R6 channel 0 first", {evt_chan, evt_code}, 2);
    step(2'b00, 2'b00, 2'b00, 1);
    check(evt_chan == 1 && evt_code == 2'd1, "R6 channel 1 second", {evt_chan, evt_code}, 5);
    step(2'b00, 2'b00, 2'b00, 1);
    check(!evt_valid, "R3 R2 queue drained", evt_valid, 0);

    // Fill with channel 0 toggles: insert, remove, insert, remove, insert
    for (int i = 0; i < 5; i++) begin
      logic [1:0] p;
      p = (i % 2 == 0) ? 2'b00 : 2'b01;
      step(p, p, 2'b01, 0);
    end
    // R5: remove while full is dropped
    step(2'b01, 2'b01, 2'b01, 0);
    check(ovf == 1'b1, "R5 drop when full", ovf, 1);
    step(2'b01, 2'b01, 2'b00, 0);
    check(ovf == 1'b0, "R5 single-cycle pulse", ovf, 0);
    // R10: spurious insert while full still flags overflow
    step(2'b00, 2'b00, 2'b01, 0);
    check(ovf == 1'b1, "R10 overflow before spurious", ovf, 1);
    // R9: pop and remove together while full: still dropped
    step(2'b01, 2'b01, 2'b01, 1);
    check(ovf == 1'b1, "R9 no same-cycle reuse", ovf, 1);
    // R4: flag stayed attached, so remove is now accepted
    step(2'b01, 2'b01, 2'b01, 0);
    check(ovf == 1'b0 && evt_valid, "R4 flag kept after drop", ovf, 0);
    // R7: hold with ready low
    step(2'b01, 2'b01, 2'b00, 0);
    check(evt_chan == 0 && evt_code == 2'd2, "R7 head held", {evt_chan, evt_code}, 2);
    for (int i = 0; i < 6; i++) step(2'b00, 2'b00, 2'b00, 1);
    check(!evt_valid, "R7 empty after drain", evt_valid, 0);

    // R11: one free slot, both channels report
    // channel 0 detached now, channel 1 attached
    for (int i = 0; i < 4; i++) begin
      logic [1:0] p;
      p = (i % 2 == 0) ? 2'b00 : 2'b01;
      step(p, p, 2'b01, 0);
    end
    step(2'b10, 2'b10, 2'b11, 0);
    check(ovf == 1'b1, "R11 channel 1 loses slot", ovf, 1);
    for (int i = 0; i < 6; i++) step(2'b11, 2'b11, 2'b00, 1);

    // near-exhaustive sweep of pin, pulse and ready combinations
    for (int pass = 0; pass < 4; pass++)
      for (int v = 0; v < 64; v++) begin
        logic [5:0] w;
        logic r;
        w = 6'(v);
        r = (pass == 3) ? (v % 7 == 0) : (((v + pass) % 3) != 0);
        step(w[1:0], w[3:2], w[5:4], r);
      end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule